// File: doc/BRIEF.md
# Accelerator Slot Allocation Manager

This block sits between an event queue of process requests and a small pool of reconfigurable accelerator slots. For each request it picks where the named process runs. The process may run in a slot that already holds it. It may be loaded into an empty slot. It may push out the resident of an occupied slot, or wait for a busy slot to drain. Otherwise it runs on the main processor in software. The choice rests on a per-process running score of benefit. That score halves on every request and then takes in the requester's fresh gain, so recent demand counts more than old demand.

Gain and overhead figures come in as tables on input ports. Gain is the software runtime minus the accelerated runtime. Overhead is the load time plus the communication cost. Each slot also reports how much time it still needs before it can be released. The block takes one request per cycle with a valid/ready handshake. It returns one registered decision, also with a valid/ready handshake. The decision carries a load request for a placement and an eviction request naming the displaced process. The block does no reconfiguration itself.

Top module: `accel_alloc_mgr`

## Requirements
- R1: Every accepted request updates all scores. Each score becomes floor(score/2). The requested process then adds its gain from `gain_tbl` (entry p at bits p*VAL_W). Decisions use the updated scores.
- R2: The add in R1 saturates at 2^VAL_W-1 and never wraps.
- R3: If the requested process is resident in a slot, the decision is HIT (code 0) with that slot. `dec_load` and `dec_evict` are both 0. No process is resident in two slots.
- R4: If it is not resident and some slot is empty, the decision is LOAD (code 1) into the lowest-numbered empty slot. This happens only when score > overhead, strictly. `dec_load`=1 and the slot becomes resident.
- R5: When all slots are occupied, the candidate slot is the one whose resident has the smallest updated score. Ties go to the lowest slot index.
- R6: With all slots occupied, the candidate's wait time zero, and score > overhead + candidate score, the decision is REPLACE (code 2). `dec_load`=1, `dec_evict`=1, and `dec_evict_pid` names the old resident.
- R7: With all slots occupied, the candidate's wait time nonzero, and score > overhead + candidate score + wait time, the decision is WAIT (code 3) on the candidate slot. No residency changes.
- R8: In every other case the decision is SOFTWARE (code 4), slot 0, with no load or evict.
- R9: A decision becomes valid in the cycle after its request is accepted. `req_ready` is low while a decision is pending and `dec_ready` is low. A stalled decision holds its value.
- R10: Reset empties all slots, clears all scores, and drops `dec_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_pid | input | PID_W | Requested process |
| gain_tbl | input | NUM_PROC*VAL_W | Per-process gain |
| ovh_tbl | input | NUM_PROC*VAL_W | Per-process overhead |
| slot_wait | input | NUM_SLOTS*VAL_W | Remaining wait time per slot |
| dec_valid | output | 1 | Decision present |
| dec_ready | input | 1 | Decision taken by consumer |
| dec_kind | output | 3 | Decision code |
| dec_slot | output | SLOT_W | Target slot |
| dec_pid | output | PID_W | Process the decision is for |
| dec_load | output | 1 | Request to load the process into the slot |
| dec_evict | output | 1 | Request to evict the slot's resident |
| dec_evict_pid | output | PID_W | Process being evicted |

## Verification
Every decision is due exactly one clock edge after the edge that accepts its request. The bench drives a request at a falling edge and lowers `req_valid` at the next falling edge. It reads the decision at that same point, half a cycle after the registering edge. Score effects are never read directly. They show up only in which decisions later requests receive. The expected decisions are therefore worked out by hand from the halving rule over the whole request sequence. A stall case holds `dec_ready` low over two falling edges to confirm that the output holds and that no request is taken.

// File: rtl/accalloc_pkg.sv
package accalloc_pkg;
  typedef enum logic [2:0] {
    DEC_HIT     = 3'd0,
    DEC_LOAD    = 3'd1,
    DEC_REPLACE = 3'd2,
    DEC_WAIT    = 3'd3,
    DEC_SOFT    = 3'd4
  } dec_kind_e;
endpackage

// File: rtl/aag_table.sv
module aag_table #(
  parameter int NUM_PROC = 4,
  parameter int VAL_W    = 16,
  localparam int PID_W   = $clog2(NUM_PROC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [PID_W-1:0] upd_pid,
  input  logic [VAL_W-1:0] gain_a [NUM_PROC],
  output logic [VAL_W-1:0] ag_nxt [NUM_PROC]
);
  logic [VAL_W-1:0] ag_q [NUM_PROC];

  // halve, then add gain when selected; clamp on carry
  function automatic logic [VAL_W-1:0] fade_acc(input logic [VAL_W-1:0] cur,
                                                input logic [VAL_W-1:0] gain,
                                                input logic             sel);
    logic [VAL_W:0] sum;
    sum = {1'b0, cur >> 1} + (sel ? {1'b0, gain} : '0);
    return sum[VAL_W] ? {VAL_W{1'b1}} : sum[VAL_W-1:0];
  endfunction

  always_comb begin
    for (int p = 0; p < NUM_PROC; p++)
      ag_nxt[p] = fade_acc(ag_q[p], gain_a[p], upd_pid == PID_W'(p));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PROC; p++) ag_q[p] <= '0;
    end else if (upd_en) begin
      for (int p = 0; p < NUM_PROC; p++) ag_q[p] <= ag_nxt[p];
    end
  end

  for (genvar p = 0; p < NUM_PROC; p++) begin : g_chk
    // R1/R2: requested entry never falls below its own gain (no wrap)
    p_req_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && upd_pid == PID_W'(p)) |=> ag_q[p] >= $past(gain_a[p]));
    // R1: other entries only decay
    p_other_decay_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && upd_pid != PID_W'(p)) |=> ag_q[p] <= $past(ag_q[p]));
  end
endmodule

// File: rtl/slot_map.sv
module slot_map #(
  parameter int NUM_PROC  = 4,
  parameter int NUM_SLOTS = 2,
  localparam int PID_W    = $clog2(NUM_PROC),
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [PID_W-1:0]  wr_pid,
  input  logic [PID_W-1:0]  q_pid,
  output logic              hit,
  output logic [SLOT_W-1:0] hit_slot,
  output logic              free_any,
  output logic [SLOT_W-1:0] free_slot,
  output logic [NUM_SLOTS-1:0] slot_vld,
  output logic [PID_W-1:0]  slot_pid [NUM_SLOTS]
);
  always_comb begin
    hit = 1'b0;
    hit_slot = '0;
    free_any = 1'b0;
    free_slot = '0;
    for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
      if (slot_vld[k] && slot_pid[k] == q_pid) begin
        hit = 1'b1;
        hit_slot = SLOT_W'(k);
      end
      if (!slot_vld[k]) begin
        free_any = 1'b1;
        free_slot = SLOT_W'(k);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_vld <= '0;
      for (int k = 0; k < NUM_SLOTS; k++) slot_pid[k] <= '0;
    end else if (wr_en) begin
      slot_vld[wr_slot] <= 1'b1;
      slot_pid[wr_slot] <= wr_pid;
    end
  end

  for (genvar a = 0; a < NUM_SLOTS; a++) begin : g_ua
    for (genvar b = a + 1; b < NUM_SLOTS; b++) begin : g_ub
      // R3: a process is resident in at most one slot
      p_unique_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld[a] && slot_vld[b]) |-> slot_pid[a] != slot_pid[b]);
    end
  end
endmodule

// File: rtl/victim_pick.sv
module victim_pick #(
  parameter int NUM_PROC  = 4,
  parameter int NUM_SLOTS = 2,
  parameter int VAL_W     = 16,
  localparam int PID_W    = $clog2(NUM_PROC),
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] slot_vld,
  input  logic [PID_W-1:0]     slot_pid [NUM_SLOTS],
  input  logic [VAL_W-1:0]     ag_nxt [NUM_PROC],
  output logic [SLOT_W-1:0]    vic_slot,
  output logic [VAL_W-1:0]     vic_ag
);
  logic found;

  always_comb begin
    found = 1'b0;
    vic_slot = '0;
    vic_ag = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (slot_vld[k] && (!found || ag_nxt[slot_pid[k]] < vic_ag)) begin
        found = 1'b1;
        vic_slot = SLOT_W'(k);
        vic_ag = ag_nxt[slot_pid[k]];
      end
    end
  end

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_min
    // R5: candidate score is no larger than any resident's score
    p_victim_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
      slot_vld[k] |-> vic_ag <= ag_nxt[slot_pid[k]]);
    // R5: a lower slot with the same score is never passed over
    p_victim_tie_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_vld[k] && ag_nxt[slot_pid[k]] == vic_ag) |-> vic_slot <= SLOT_W'(k));
  end
endmodule

// File: rtl/accel_alloc_mgr.sv
module accel_alloc_mgr
  import accalloc_pkg::*;
#(
  parameter int NUM_PROC  = 4,
  parameter int NUM_SLOTS = 2,
  parameter int VAL_W     = 16,
  localparam int PID_W    = $clog2(NUM_PROC),
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [PID_W-1:0]           req_pid,
  input  logic [NUM_PROC*VAL_W-1:0]  gain_tbl,
  input  logic [NUM_PROC*VAL_W-1:0]  ovh_tbl,
  input  logic [NUM_SLOTS*VAL_W-1:0] slot_wait,
  output logic                       dec_valid,
  input  logic                       dec_ready,
  output logic [2:0]                 dec_kind,
  output logic [SLOT_W-1:0]          dec_slot,
  output logic [PID_W-1:0]           dec_pid,
  output logic                       dec_load,
  output logic                       dec_evict,
  output logic [PID_W-1:0]           dec_evict_pid
);
  localparam int CMP_W = VAL_W + 2;

  logic [VAL_W-1:0] gain_a [NUM_PROC];
  logic [VAL_W-1:0] ovh_a  [NUM_PROC];
  logic [VAL_W-1:0] wait_a [NUM_SLOTS];
  logic [VAL_W-1:0] ag_nxt [NUM_PROC];

  for (genvar p = 0; p < NUM_PROC; p++) begin : g_ptab
    assign gain_a[p] = gain_tbl[p*VAL_W +: VAL_W];
    assign ovh_a[p]  = ovh_tbl[p*VAL_W +: VAL_W];
  end
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_stab
    assign wait_a[k] = slot_wait[k*VAL_W +: VAL_W];
  end

  // named internal events
  logic ev_accept, ev_hit, ev_load, ev_replace, ev_wait, ev_place;

  assign req_ready = !dec_valid || dec_ready;
  assign ev_accept = req_valid && req_ready;

  logic                 hit, free_any;
  logic [SLOT_W-1:0]    hit_slot, free_slot, vic_slot;
  logic [NUM_SLOTS-1:0] slot_vld;
  logic [PID_W-1:0]     slot_pid [NUM_SLOTS];
  logic [VAL_W-1:0]     vic_ag;
  dec_kind_e            nxt_kind;
  logic [SLOT_W-1:0]    nxt_slot;

  aag_table #(.NUM_PROC(NUM_PROC), .VAL_W(VAL_W)) u_ag (
    .clk(clk), .rst_n(rst_n), .upd_en(ev_accept), .upd_pid(req_pid),
    .gain_a(gain_a), .ag_nxt(ag_nxt));

  slot_map #(.NUM_PROC(NUM_PROC), .NUM_SLOTS(NUM_SLOTS)) u_slots (
    .clk(clk), .rst_n(rst_n), .wr_en(ev_place), .wr_slot(nxt_slot),
    .wr_pid(req_pid), .q_pid(req_pid), .hit(hit), .hit_slot(hit_slot),
    .free_any(free_any), .free_slot(free_slot), .slot_vld(slot_vld),
    .slot_pid(slot_pid));

  victim_pick #(.NUM_PROC(NUM_PROC), .NUM_SLOTS(NUM_SLOTS), .VAL_W(VAL_W)) u_vic (
    .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_pid(slot_pid),
    .ag_nxt(ag_nxt), .vic_slot(vic_slot), .vic_ag(vic_ag));

  // threshold arithmetic, widened so the sums cannot wrap
  logic [CMP_W-1:0] req_ag_x, thr_load, thr_rep, thr_wait;
  logic [VAL_W-1:0] vic_wait;

  assign vic_wait = wait_a[vic_slot];
  assign req_ag_x = CMP_W'(ag_nxt[req_pid]);
  assign thr_load = CMP_W'(ovh_a[req_pid]);
  assign thr_rep  = thr_load + CMP_W'(vic_ag);
  assign thr_wait = thr_rep + CMP_W'(vic_wait);

  always_comb begin
    nxt_kind = DEC_SOFT;
    nxt_slot = '0;
    if (hit) begin
      nxt_kind = DEC_HIT;
      nxt_slot = hit_slot;
    end else if (free_any) begin
      if (req_ag_x > thr_load) begin
        nxt_kind = DEC_LOAD;
        nxt_slot = free_slot;
      end
    end else if (vic_wait == '0) begin
      if (req_ag_x > thr_rep) begin
        nxt_kind = DEC_REPLACE;
        nxt_slot = vic_slot;
      end
    end else if (req_ag_x > thr_wait) begin
      nxt_kind = DEC_WAIT;
      nxt_slot = vic_slot;
    end
  end

  assign ev_hit     = ev_accept && nxt_kind == DEC_HIT;
  assign ev_load    = ev_accept && nxt_kind == DEC_LOAD;
  assign ev_replace = ev_accept && nxt_kind == DEC_REPLACE;
  assign ev_wait    = ev_accept && nxt_kind == DEC_WAIT;
  assign ev_place   = ev_load || ev_replace;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid     <= 1'b0;
      dec_kind      <= DEC_SOFT;
      dec_slot      <= '0;
      dec_pid       <= '0;
      dec_load      <= 1'b0;
      dec_evict     <= 1'b0;
      dec_evict_pid <= '0;
    end else if (ev_accept) begin
      dec_valid     <= 1'b1;
      dec_kind      <= nxt_kind;
      dec_slot      <= nxt_slot;
      dec_pid       <= req_pid;
      dec_load      <= ev_place;
      dec_evict     <= ev_replace;
      dec_evict_pid <= ev_replace ? slot_pid[vic_slot] : '0;
    end else if (dec_ready) begin
      dec_valid     <= 1'b0;
    end
  end

  // R9: an accepted request yields a decision on the next edge
  p_dec_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> dec_valid && dec_pid == $past(req_pid));
  // R9: a stalled decision holds
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=> dec_valid && $stable(dec_kind) && $stable(dec_slot)
                                  && $stable(dec_pid));
  // R6: a replacement always targets an occupied slot
  p_evict_occupied_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_replace |-> slot_vld[vic_slot]);
  // R4: a load goes into a slot that was empty
  p_load_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> $past(!slot_vld[nxt_slot]));
  // R7: waiting changes no residency
  p_wait_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wait |=> $stable(slot_vld));
  // R3: a hit does not request loading
  p_hit_noload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> !dec_load && !dec_evict);
endmodule

// File: tb/tb_accel_alloc_mgr.sv
`timescale 1ns/1ps
module tb_accel_alloc_mgr;
  localparam int K_HIT = 0, K_LOAD = 1, K_REP = 2, K_WAIT = 3, K_SOFT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_pid = '0;
  logic [63:0] gain_tbl = '0;
  logic [63:0] ovh_tbl = '0;
  logic [31:0] slot_wait = '0;
  logic        dec_valid;
  logic        dec_ready = 1'b1;
  logic [2:0]  dec_kind;
  logic [0:0]  dec_slot;
  logic [1:0]  dec_pid;
  logic        dec_load, dec_evict;
  logic [1:0]  dec_evict_pid;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  accel_alloc_mgr dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_pid(req_pid), .gain_tbl(gain_tbl), .ovh_tbl(ovh_tbl), .slot_wait(slot_wait),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_kind(dec_kind),
    .dec_slot(dec_slot), .dec_pid(dec_pid), .dec_load(dec_load),
    .dec_evict(dec_evict), .dec_evict_pid(dec_evict_pid));

  typedef struct packed {
    logic [1:0]  pid;
    logic [15:0] w0;
    logic [15:0] w1;
    logic [2:0]  kind;
    logic        slot;
    logic        ev;
    logic [1:0]  epid;
  } vec_t;

  // gains {190,80,25,100}, overheads {200,50,10,1000}; scores worked by hand
  localparam vec_t VECS [12] = '{
    '{2'd0, 16'd0, 16'd0, 3'd4, 1'b0, 1'b0, 2'd0},  // ag0=190 <= 200
    '{2'd0, 16'd0, 16'd0, 3'd1, 1'b0, 1'b0, 2'd0},  // ag0=285
    '{2'd2, 16'd0, 16'd0, 3'd1, 1'b1, 1'b0, 2'd0},  // ag0=142 ag2=25
    '{2'd0, 16'd0, 16'd0, 3'd0, 1'b0, 1'b0, 2'd0},  // ag0=261
    '{2'd1, 16'd0, 16'd0, 3'd2, 1'b1, 1'b1, 2'd2},  // 80 > 50+6
    '{2'd3, 16'd0, 16'd0, 3'd4, 1'b0, 1'b0, 2'd0},  // 100 <= 1000+40
    '{2'd1, 16'd0, 16'd0, 3'd0, 1'b1, 1'b0, 2'd0},
    '{2'd0, 16'd0, 16'd0, 3'd0, 1'b0, 1'b0, 2'd0},  // ag=[206,50,0,25]
    '{2'd2, 16'd5, 16'd5, 3'd4, 1'b0, 1'b0, 2'd0},  // 25 <= 10+25+5
    '{2'd2, 16'd5, 16'd5, 3'd3, 1'b1, 1'b0, 2'd0},  // 37 > 10+12+5
    '{2'd2, 16'd0, 16'd0, 3'd2, 1'b1, 1'b1, 2'd1},  // 43 > 10+6
    '{2'd2, 16'd0, 16'd0, 3'd0, 1'b1, 1'b0, 2'd0}   // resident after replace
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string kind_req(input int k);
    case (k)
      K_HIT:   return "R3";
      K_LOAD:  return "R4";
      K_REP:   return "R6";
      K_WAIT:  return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_tab(input int g0, g1, g2, g3, o0, o1, o2, o3);
    gain_tbl = {16'(g3), 16'(g2), 16'(g1), 16'(g0)};
    ovh_tbl  = {16'(o3), 16'(o2), 16'(o1), 16'(o0)};
  endtask

  // issue one request, check its decision half a cycle after the registering edge
  task automatic req_chk(input string req, input int pid, input int w0, input int w1,
                         input int kind, input int slot, input int ev, input int epid);
    @(negedge clk);
    req_valid = 1'b1;
    req_pid = 2'(pid);
    slot_wait = {16'(w1), 16'(w0)};
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "dec_valid", int'(dec_valid), 1);
    chk(req, "dec_kind", int'(dec_kind), kind);
    chk(req, "dec_slot", int'(dec_slot), slot);
    chk(req, "dec_load", int'(dec_load), (kind == K_LOAD || kind == K_REP) ? 1 : 0);
    chk(req, "dec_evict", int'(dec_evict), ev);
    if (ev != 0) chk("R6", "dec_evict_pid", int'(dec_evict_pid), epid);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    set_tab(190, 80, 25, 100, 200, 50, 10, 1000);
    do_reset();
    // R10: reset state
    chk("R10", "dec_valid", int'(dec_valid), 0);
    chk("R10", "req_ready", int'(req_ready), 1);

    // R1 fading sequence: each vector's score depends on all earlier ones
    for (int i = 0; i < 12; i++) begin
      req_chk(kind_req(int'(VECS[i].kind)), int'(VECS[i].pid), int'(VECS[i].w0),
              int'(VECS[i].w1), int'(VECS[i].kind), int'(VECS[i].slot),
              int'(VECS[i].ev), int'(VECS[i].epid));
    end
    @(negedge clk);
    chk("R9", "dec_valid drops", int'(dec_valid), 0);

    // R10: slots emptied by reset, p2 (was in slot 1) loads to slot 0
    do_reset();
    req_chk("R10", 2, 0, 0, K_LOAD, 0, 0, 0);

    // R5: tie on candidate score goes to the lowest slot
    do_reset();
    set_tab(40, 40, 100, 0, 10, 10, 10, 10);
    req_chk("R4", 0, 0, 0, K_LOAD, 0, 0, 0);
    set_tab(40, 20, 100, 0, 10, 10, 10, 10);
    req_chk("R4", 1, 0, 0, K_LOAD, 1, 0, 0);   // ag0=20, ag1=20
    req_chk("R5", 2, 0, 0, K_REP, 0, 1, 0);    // both 10, slot 0 chosen

    // R4: strict comparison against overhead
    do_reset();
    set_tab(50, 0, 0, 0, 50, 0, 0, 0);
    req_chk("R4", 0, 0, 0, K_SOFT, 0, 0, 0);   // 50 not > 50
    set_tab(50, 0, 0, 0, 49, 0, 0, 0);
    req_chk("R4", 0, 0, 0, K_LOAD, 0, 0, 0);   // 75 > 49

    // R2: saturation; a wrapped sum (32766) would stay below 65534
    do_reset();
    set_tab(0, 0, 0, 65535, 0, 0, 0, 65535);
    req_chk("R2", 3, 0, 0, K_SOFT, 0, 0, 0);
    set_tab(0, 0, 0, 65535, 0, 0, 0, 65534);
    req_chk("R2", 3, 0, 0, K_LOAD, 0, 0, 0);

    // R9: stall holds the decision and blocks new requests
    set_tab(50, 0, 0, 65535, 49, 0, 0, 65534);
    @(negedge clk);
    dec_ready = 1'b0;
    req_valid = 1'b1;
    req_pid = 2'd3;
    @(negedge clk);
    chk("R9", "dec_kind", int'(dec_kind), K_HIT);
    chk("R9", "req_ready stalled", int'(req_ready), 0);
    req_pid = 2'd0;
    @(negedge clk);
    chk("R9", "held dec_kind", int'(dec_kind), K_HIT);
    chk("R9", "held dec_pid", int'(dec_pid), 3);
    chk("R9", "held dec_valid", int'(dec_valid), 1);
    dec_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "next dec_pid", int'(dec_pid), 0);
    chk("R4", "next dec_kind", int'(dec_kind), K_LOAD);
    chk("R4", "next dec_slot", int'(dec_slot), 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule